// File: doc/BRIEF.md
# Shared-Memory Peer Doorbell Register Block

This block is the small control window of a device that lets several machines share one memory region and signal each other. Software reaches it through a synchronous register bus with 8-bit byte addresses and 32-bit data. The window holds a one-bit interrupt enable, a one-bit pending flag that is set by incoming peer events and cleared by reading it, a read-only identity word, and a write-only doorbell. A doorbell write names a target peer in its upper half and a vector in its lower half.

The target peer ID goes out combinationally on a lookup port in the same cycle as the write. The lookup answers with whether that peer is connected and how many vectors it has. The write becomes an outgoing ring request only when the block is configured for interrupts, setup is complete, the peer is present and the vector exists. Otherwise it is dropped without any trace.

The outgoing ring request is a one-cycle `ring_valid` pulse with no ready signal, so there is no back-pressure. The consumer must accept every pulse in the cycle it appears. Incoming `peer_evt` is also a plain pulse. A level-sensitive legacy interrupt is produced from the pending flag and the enable bit, but only when the device reports no message-signalled interrupt capability.

Top module: `shm_doorbell_regs`

## Requirements
- R1: After reset, the enable bit and the pending bit are 0, `irq_legacy` is 0, `ring_valid` is 0 and `reg_rdata` is 0.
- R2: The enable register at byte offset 0 stores write-data bit 0 only. A read returns it in bit 0, with bits 31:1 reading 0. Read data appears on `reg_rdata` in the cycle after the read strobe and is 0 in cycles without a read.
- R3: The pending register at offset 4 is set by a `peer_evt` pulse. A read returns its value in bit 0 and clears it. Writes to offset 4 have no effect.
- R4: When `peer_evt` and a read of offset 4 occur in the same cycle, that read returns the earlier value and the pending bit ends up set.
- R5: `irq_legacy` is 1 exactly when the pending bit and the enable bit are both 1 and `cfg_has_msix` is 0.
- R6: Offset 8 reads 0 when `cfg_irq_en` is 0. Otherwise it reads `cfg_self_id` zero-extended to 32 bits.
- R7: A doorbell write to offset 12 carries the peer ID in bits 31:16 and the vector in bits 15:0. The peer ID is driven on `lkp_peer` in the same cycle. An accepted write raises `ring_valid` for exactly one cycle, one cycle after the write, with `ring_peer` and `ring_vec` equal to those fields.
- R8: A doorbell write is dropped when `cfg_irq_en` or `cfg_setup_done` is 0.
- R9: A doorbell write is dropped when `lkp_connected` is 0 or the vector is not less than `lkp_num_vec`.
- R10: Reads of offset 12 and of reserved offsets 16 to 252 return 0. Writes to offset 8 or to reserved offsets change no register and produce no ring request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_irq_en | input | 1 | Device configured for interrupts |
| cfg_setup_done | input | 1 | Interrupt setup complete |
| cfg_has_msix | input | 1 | Message-signalled interrupts present; suppresses legacy line |
| cfg_self_id | input | 16 | Own peer ID |
| reg_addr | input | 8 | Byte address (word aligned) |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after strobe |
| lkp_peer | output | 16 | Peer ID being looked up (combinational) |
| lkp_connected | input | 1 | Looked-up peer is connected |
| lkp_num_vec | input | 16 | Number of vectors of looked-up peer |
| ring_valid | output | 1 | One-cycle ring request, no back-pressure |
| ring_peer | output | 16 | Target peer of the ring request |
| ring_vec | output | 16 | Vector of the ring request |
| peer_evt | input | 1 | Incoming peer interrupt event pulse |
| irq_legacy | output | 1 | Level-sensitive legacy interrupt |

## Verification
The bench sweeps doorbell writes over a grid of peer IDs and vectors under every combination of configured and setup-complete. The lookup model makes the vector count vary per peer, so the check at `vec == num_vec` catches an off-by-one comparison, which would ring a missing vector. An event that coincides with a status read is targeted directly, because a design that gives the clear priority loses the interrupt. The legacy line is swept across enable, pending and capability settings, which catches an output that ignores the capability flag. All reserved offsets are read after being written with ones, which exposes any decode aliasing.

// File: rtl/shm_db_pkg.sv
package shm_db_pkg;
  localparam int WORD_EN   = 0;
  localparam int WORD_PEND = 1;
  localparam int WORD_ID   = 2;
  localparam int WORD_RING = 3;

  typedef struct packed {
    logic en;
    logic pend;
    logic id;
    logic ring;
  } db_sel_t;
endpackage

// File: rtl/shm_db_decode.sv
module shm_db_decode
  import shm_db_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output db_sel_t           rd_sel,
  output db_sel_t           wr_sel
);
  localparam int WI_W = ADDR_W - 2;
  logic [WI_W-1:0] widx;
  db_sel_t hit;

  assign widx = addr[ADDR_W-1:2];

  always_comb begin
    hit.en   = (widx == WI_W'(WORD_EN));
    hit.pend = (widx == WI_W'(WORD_PEND));
    hit.id   = (widx == WI_W'(WORD_ID));
    hit.ring = (widx == WI_W'(WORD_RING));
  end

  assign rd_sel = rd ? hit : '0;
  assign wr_sel = wr ? hit : '0;
endmodule

// File: rtl/shm_db_irq.sv
module shm_db_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic en_wr,
  input  logic en_wdata,
  input  logic pend_rd,
  input  logic peer_evt,
  input  logic has_msix,
  output logic en_bit,
  output logic pend_bit,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_bit   <= 1'b0;
      pend_bit <= 1'b0;
    end else begin
      if (en_wr) en_bit <= en_wdata;
      if (peer_evt)     pend_bit <= 1'b1;
      else if (pend_rd) pend_bit <= 1'b0;
    end
  end

  assign irq = pend_bit & en_bit & ~has_msix;
endmodule

// File: rtl/shm_db_ring.sv
module shm_db_ring #(
  parameter int ID_W  = 16,
  parameter int VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ring_wr,
  input  logic             irq_en,
  input  logic             setup_done,
  input  logic [ID_W-1:0]  peer,
  input  logic [VEC_W-1:0] vec,
  input  logic             lkp_connected,
  input  logic [VEC_W-1:0] lkp_num_vec,
  output logic             ring_valid,
  output logic [ID_W-1:0]  ring_peer,
  output logic [VEC_W-1:0] ring_vec
);
  logic deliver;

  assign deliver = ring_wr && irq_en && setup_done
                   && lkp_connected && (vec < lkp_num_vec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_valid <= 1'b0;
      ring_peer  <= '0;
      ring_vec   <= '0;
    end else begin
      ring_valid <= deliver;
      if (deliver) begin
        ring_peer <= peer;
        ring_vec  <= vec;
      end
    end
  end
endmodule

// File: rtl/shm_doorbell_regs.sv
module shm_doorbell_regs
  import shm_db_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int ID_W   = 16,
  parameter int VEC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_irq_en,
  input  logic              cfg_setup_done,
  input  logic              cfg_has_msix,
  input  logic [ID_W-1:0]   cfg_self_id,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [ID_W-1:0]   lkp_peer,
  input  logic              lkp_connected,
  input  logic [VEC_W-1:0]  lkp_num_vec,
  output logic              ring_valid,
  output logic [ID_W-1:0]   ring_peer,
  output logic [VEC_W-1:0]  ring_vec,
  input  logic              peer_evt,
  output logic              irq_legacy
);
  localparam int PEER_LSB = DATA_W - ID_W;

  db_sel_t rd_sel, wr_sel;
  logic    en_bit, pend_bit;
  logic [VEC_W-1:0] wr_vec;

  assign lkp_peer = reg_wdata[DATA_W-1:PEER_LSB];
  assign wr_vec   = reg_wdata[VEC_W-1:0];

  shm_db_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (reg_addr),
    .rd     (reg_rd),
    .wr     (reg_wr),
    .rd_sel (rd_sel),
    .wr_sel (wr_sel)
  );

  shm_db_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_wr    (wr_sel.en),
    .en_wdata (reg_wdata[0]),
    .pend_rd  (rd_sel.pend),
    .peer_evt (peer_evt),
    .has_msix (cfg_has_msix),
    .en_bit   (en_bit),
    .pend_bit (pend_bit),
    .irq      (irq_legacy)
  );

  shm_db_ring #(.ID_W(ID_W), .VEC_W(VEC_W)) u_ring (
    .clk           (clk),
    .rst_n         (rst_n),
    .ring_wr       (wr_sel.ring),
    .irq_en        (cfg_irq_en),
    .setup_done    (cfg_setup_done),
    .peer          (lkp_peer),
    .vec           (wr_vec),
    .lkp_connected (lkp_connected),
    .lkp_num_vec   (lkp_num_vec),
    .ring_valid    (ring_valid),
    .ring_peer     (ring_peer),
    .ring_vec      (ring_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      if (rd_sel.en)   reg_rdata <= DATA_W'(en_bit);
      if (rd_sel.pend) reg_rdata <= DATA_W'(pend_bit);
      if (rd_sel.id)   reg_rdata <= cfg_irq_en ? DATA_W'(cfg_self_id) : '0;
    end
  end
endmodule

// File: rtl/shm_doorbell_regs_chk.sv
module shm_doorbell_regs_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int ID_W   = 16,
  parameter int VEC_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_irq_en,
  input logic              cfg_setup_done,
  input logic              cfg_has_msix,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              lkp_connected,
  input logic [VEC_W-1:0]  lkp_num_vec,
  input logic              ring_valid,
  input logic [ID_W-1:0]   ring_peer,
  input logic [VEC_W-1:0]  ring_vec,
  input logic              peer_evt,
  input logic              irq_legacy,
  input logic              en_bit,
  input logic              pend_bit
);
  localparam int WI_W = ADDR_W - 2;

  // R7
  ring_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ring_valid |-> ($past(reg_wr) && $past(reg_addr[ADDR_W-1:2]) == WI_W'(3)
                    && $past(reg_wdata[DATA_W-1:DATA_W-ID_W]) == ring_peer));

  // R8
  ring_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ring_valid |-> ($past(cfg_irq_en) && $past(cfg_setup_done)));

  // R9
  ring_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ring_valid |-> ($past(lkp_connected) && ring_vec < $past(lkp_num_vec)));

  // R3
  evt_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    peer_evt |=> pend_bit);

  // R3
  read_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr[ADDR_W-1:2] == WI_W'(1) && !peer_evt) |=> !pend_bit);

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_legacy |-> (!cfg_has_msix && en_bit && pend_bit));

  // R6
  id_unconfigured_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr[ADDR_W-1:2] == WI_W'(2) && !cfg_irq_en) |=> reg_rdata == '0);
endmodule

bind shm_doorbell_regs shm_doorbell_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .VEC_W(VEC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_irq_en(cfg_irq_en),
  .cfg_setup_done(cfg_setup_done), .cfg_has_msix(cfg_has_msix),
  .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .lkp_connected(lkp_connected), .lkp_num_vec(lkp_num_vec),
  .ring_valid(ring_valid), .ring_peer(ring_peer), .ring_vec(ring_vec),
  .peer_evt(peer_evt), .irq_legacy(irq_legacy),
  .en_bit(en_bit), .pend_bit(pend_bit)
);

// File: tb/tb_shm_doorbell_regs.sv
module tb_shm_doorbell_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_irq_en = 1'b0, cfg_setup_done = 1'b0, cfg_has_msix = 1'b0;
  logic [15:0] cfg_self_id = 16'hBEEF;
  logic [7:0]  reg_addr = '0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] lkp_peer;
  logic        lkp_connected;
  logic [15:0] lkp_num_vec;
  logic        ring_valid;
  logic [15:0] ring_peer, ring_vec;
  logic        peer_evt = 1'b0;
  logic        irq_legacy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  // peers 0..2 connected, peer p has p+1 vectors
  always_comb begin
    lkp_connected = (lkp_peer < 16'd3);
    lkp_num_vec   = lkp_peer + 16'd1;
  end

  shm_doorbell_regs dut (
    .clk(clk), .rst_n(rst_n), .cfg_irq_en(cfg_irq_en),
    .cfg_setup_done(cfg_setup_done), .cfg_has_msix(cfg_has_msix),
    .cfg_self_id(cfg_self_id), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lkp_peer(lkp_peer), .lkp_connected(lkp_connected),
    .lkp_num_vec(lkp_num_vec), .ring_valid(ring_valid),
    .ring_peer(ring_peer), .ring_vec(ring_vec), .peer_evt(peer_evt),
    .irq_legacy(irq_legacy)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic pulse_evt();
    @(negedge clk); peer_evt = 1'b1;
    @(negedge clk); peer_evt = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(irq_legacy == 0, "R1 irq", 32'(irq_legacy), 0);
    chk(ring_valid == 0, "R1 ring_valid", 32'(ring_valid), 0);
    chk(reg_rdata == 0, "R1 rdata", reg_rdata, 0);
    do_rd(8'd0, d); chk(d == 0, "R1 enable", d, 0);
    do_rd(8'd4, d); chk(d == 0, "R1 pending", d, 0);
    @(negedge clk); chk(reg_rdata == 0, "R2 idle rdata", reg_rdata, 0);

    // R2 enable register keeps bit 0 only
    do_wr(8'd0, 32'hFFFF_FFFF); do_rd(8'd0, d); chk(d == 32'd1, "R2 en set", d, 1);
    do_wr(8'd0, 32'hFFFF_FFFE); do_rd(8'd0, d); chk(d == 32'd0, "R2 en clr", d, 0);

    // R3 writes to pending ignored
    do_wr(8'd4, 32'hFFFF_FFFF); do_rd(8'd4, d); chk(d == 0, "R3 write ignored", d, 0);

    // R5 / R3 sweep over enable and capability
    for (int m = 0; m < 2; m++) begin
      for (int x = 0; x < 2; x++) begin
        do_wr(8'd0, 32'(m));
        cfg_has_msix = x[0];
        @(negedge clk);
        chk(irq_legacy == 0, "R5 idle irq", 32'(irq_legacy), 0);
        pulse_evt();
        chk(irq_legacy == (m[0] & ~x[0]), "R5 irq level", 32'(irq_legacy),
            32'(m[0] & ~x[0]));
        do_rd(8'd4, d); chk(d == 1, "R3 pending read", d, 1);
        chk(irq_legacy == 0, "R5 irq drops after read", 32'(irq_legacy), 0);
        do_rd(8'd4, d); chk(d == 0, "R3 cleared by read", d, 0);
      end
    end
    cfg_has_msix = 1'b0;
    do_wr(8'd0, 32'd1);

    // R4 event coincides with read
    @(negedge clk); reg_addr = 8'd4; reg_rd = 1'b1; peer_evt = 1'b1;
    @(negedge clk); reg_rd = 1'b0; peer_evt = 1'b0; d = reg_rdata;
    chk(d == 0, "R4 read returns prior", d, 0);
    chk(irq_legacy == 1, "R4 irq kept", 32'(irq_legacy), 1);
    do_rd(8'd4, d); chk(d == 1, "R4 event not lost", d, 1);

    // R6 identity word
    cfg_irq_en = 1'b0; do_rd(8'd8, d); chk(d == 0, "R6 unconfigured", d, 0);
    cfg_irq_en = 1'b1; do_rd(8'd8, d); chk(d == 32'h0000_BEEF, "R6 id", d, 32'h0000_BEEF);
    cfg_self_id = 16'hFFFF; do_rd(8'd8, d); chk(d == 32'h0000_FFFF, "R6 id zero-ext", d, 32'h0000_FFFF);

    // R7 R8 R9 doorbell sweep
    for (int c = 0; c < 4; c++) begin
      cfg_irq_en = c[0]; cfg_setup_done = c[1];
      for (int p = 0; p < 5; p++) begin
        for (int v = 0; v < 5; v++) begin
          bit exp_ok;
          exp_ok = c[0] && c[1] && (p < 3) && (v < p + 1);
          @(negedge clk); reg_addr = 8'd12; reg_wdata = {16'(p), 16'(v)}; reg_wr = 1'b1;
          #1 chk(lkp_peer == 16'(p), "R7 lookup peer", 32'(lkp_peer), 32'(p));
          @(negedge clk); reg_wr = 1'b0;
          chk(ring_valid == exp_ok, "R8 R9 accept", 32'(ring_valid), 32'(exp_ok));
          if (exp_ok) begin
            chk(ring_peer == 16'(p), "R7 peer", 32'(ring_peer), 32'(p));
            chk(ring_vec == 16'(v), "R7 vec", 32'(ring_vec), 32'(v));
          end
          @(negedge clk);
          chk(ring_valid == 0, "R7 single pulse", 32'(ring_valid), 0);
        end
      end
    end

    // R10 reserved and write-only words
    cfg_irq_en = 1'b1; cfg_setup_done = 1'b1; cfg_self_id = 16'h1234;
    do_wr(8'd0, 32'd0);
    do_wr(8'd8, 32'hFFFF_FFFF);
    chk(ring_valid == 0, "R10 id write no ring", 32'(ring_valid), 0);
    do_rd(8'd8, d); chk(d == 32'h1234, "R10 id unchanged", d, 32'h1234);
    do_rd(8'd12, d); chk(d == 0, "R10 doorbell reads 0", d, 0);
    for (int a = 16; a < 256; a += 4) begin
      do_wr(8'(a), 32'h0000_0000);
      chk(ring_valid == 0, "R10 reserved write no ring", 32'(ring_valid), 0);
      do_wr(8'(a), 32'hFFFF_FFFF);
      do_rd(8'(a), d); chk(d == 0, "R10 reserved read", d, 0);
    end
    do_rd(8'd0, d); chk(d == 0, "R10 enable untouched", d, 0);
    do_rd(8'd4, d); chk(d == 0, "R10 pending untouched", d, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule